// File: doc/BRIEF.md
# Dual-Edge Word and Block Parity Checker

This block watches a double-data-rate input stream after capture. Each cycle of the core clock it may take one word pair: the word latched on the rising edge of the source clock and the word latched on the falling edge. In word mode, each word arrives with its own parity bit on a dedicated input. The block checks each word against that bit and raises a separate alarm for the rising-edge lane and the falling-edge lane.

In block mode, the frame input acts as the parity bit for a group of consecutive words. A start pulse opens each group. The frame level is taken only with the first pair of the group. When the last pair has been seen, the block compares the frame bit with the parity of every data bit in the group and pulses the frame alarm on a mismatch. A configuration input selects the mode. Another input selects even or odd parity sense. Every alarm is a registered pulse one cycle wide. A sticky status register is left to the surrounding logic.

Top module: `dual_edge_parity_checker`

## Requirements
- R1: While reset is high, and on the first cycle after it, all three alarm outputs are low.
- R2: In word mode (mode_block=0), a valid pair whose rising-edge word fails its parity check pulses alarm_rise high for exactly the one cycle after the capture edge.
- R3: In word mode, a parity failure on the falling-edge word pulses alarm_fall in the same way. The two lanes are independent: a failure on one lane never raises the other lane's alarm.
- R4: The check counts the ones in the 16 data bits plus the parity bit. With odd_sense=0 a word passes when that count is even. With odd_sense=1 it passes when that count is odd.
- R5: In block mode (mode_block=1), a block is 4 words, taken as 2 consecutive valid pairs in the order rise, fall, rise, fall. After the edge that captures the second pair, alarm_frame pulses for one cycle if the count of ones over all 64 data bits plus the frame bit does not match the parity sense.
- R6: The frame bit is sampled only with the pair that carries block_start. The frame level during later pairs of the block has no effect.
- R7: A block_start that arrives while a block is open discards the partial block and opens a new one with that pair.
- R8: In block mode, valid pairs that arrive while no block is open are ignored and raise no alarm.
- R9: The alarms of the inactive mode stay low. alarm_frame is low in word mode. alarm_rise and alarm_fall are low in block mode.
- R10: A cycle with pair_valid low never causes an alarm, whatever the data, parity or frame inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_block | input | 1 | 0 = per-word parity, 1 = block parity on frame |
| odd_sense | input | 1 | 0 = even parity, 1 = odd parity |
| pair_valid | input | 1 | A captured word pair is present this cycle |
| rise_word | input | 16 | Word captured on the rising source edge |
| rise_par | input | 1 | Parity bit for rise_word |
| fall_word | input | 16 | Word captured on the falling source edge |
| fall_par | input | 1 | Parity bit for fall_word |
| frame_bit | input | 1 | Block parity bit, sampled with the first pair |
| block_start | input | 1 | Marks the first pair of a block |
| alarm_rise | output | 1 | Rising-edge word parity error pulse |
| alarm_fall | output | 1 | Falling-edge word parity error pulse |
| alarm_frame | output | 1 | Block parity error pulse |

## Verification
The word alarms are due one cycle after the edge that captures the pair. The block alarm is due one cycle after the edge that captures the last pair of the block. Cycles in between must show all alarms low. The driver applies one input set per cycle and queues the alarm triple expected for that cycle, so the queued value is always the result of that cycle's inputs. The monitor removes one entry a quarter period after each following rising edge and compares all three alarms. An early, late or stretched pulse therefore shows up as a mismatch in a neighbouring entry.

// File: rtl/parity_chk_pkg.sv
package parity_chk_pkg;

  typedef enum logic {
    CHK_WORD  = 1'b0,
    CHK_BLOCK = 1'b1
  } chk_mode_e;

  localparam int unsigned LANES    = 2;
  localparam int unsigned LANE_RISE = 0;
  localparam int unsigned LANE_FALL = 1;

  // Returns 1 when the parity of data plus check bit differs from the sense.
  function automatic logic parity_bad(input logic data_xor,
                                      input logic check_bit,
                                      input logic odd);
    return (data_xor ^ check_bit) != odd;
  endfunction

endpackage

// File: rtl/word_parity_lane.sv
module word_parity_lane #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic              par,
  input  logic              odd,
  output logic              alarm
);
  import parity_chk_pkg::*;

  logic alarm_q;
  logic word_xor;

  assign word_xor = ^word;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= enable && valid && parity_bad(word_xor, par, odd);
    end
  end

  assign alarm = alarm_q;

  // R10: a pulse only follows a valid, enabled cycle
  p_lane_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    alarm_q |-> $past(valid && enable));

endmodule

// File: rtl/block_parity_acc.sv
module block_parity_acc #(
  parameter int unsigned WORD_W          = 16,
  parameter int unsigned WORDS_PER_BLOCK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              valid,
  input  logic              start,
  input  logic [WORD_W-1:0] rise_word,
  input  logic [WORD_W-1:0] fall_word,
  input  logic              frame,
  input  logic              odd,
  output logic              alarm
);
  import parity_chk_pkg::*;

  localparam int unsigned PAIRS = WORDS_PER_BLOCK / 2;
  localparam int unsigned CNT_W = (PAIRS > 1) ? $clog2(PAIRS + 1) : 1;

  logic             open_q;
  logic [CNT_W-1:0] cnt_q;
  logic             acc_q;
  logic             fbit_q;
  logic             alarm_q;
  logic             pair_xor;
  logic             acc_next;
  logic             last_pair;

  assign pair_xor  = (^rise_word) ^ (^fall_word);
  assign acc_next  = acc_q ^ pair_xor;
  assign last_pair = (cnt_q == CNT_W'(PAIRS - 1));

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      open_q  <= 1'b0;
      cnt_q   <= '0;
      acc_q   <= 1'b0;
      fbit_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      alarm_q <= 1'b0;
      if (valid && start) begin
        fbit_q <= frame;
        if (PAIRS == 1) begin
          alarm_q <= parity_bad(pair_xor, frame, odd);
          open_q  <= 1'b0;
          cnt_q   <= '0;
          acc_q   <= 1'b0;
        end else begin
          open_q <= 1'b1;
          cnt_q  <= CNT_W'(1);
          acc_q  <= pair_xor;
        end
      end else if (valid && open_q) begin
        if (last_pair) begin
          alarm_q <= parity_bad(acc_next, fbit_q, odd);
          open_q  <= 1'b0;
          cnt_q   <= '0;
          acc_q   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          acc_q <= acc_next;
        end
      end
    end
  end

  assign alarm = alarm_q;

  // R5: the pair counter never passes the block length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (cnt_q < CNT_W'(PAIRS)));

  // R7: a start pair always (re)opens a block at its first position
  p_start_opens_r7: assert property (@(posedge clk) disable iff (rst)
    (enable && valid && start && PAIRS > 1) |=> (open_q && cnt_q == CNT_W'(1)));

  // R8: no alarm unless a block was open or just started
  p_alarm_in_block_r8: assert property (@(posedge clk) disable iff (rst)
    alarm_q |-> $past(valid && (open_q || start)));

endmodule

// File: rtl/dual_edge_parity_checker.sv
module dual_edge_parity_checker #(
  parameter int unsigned WORD_W          = 16,
  parameter int unsigned WORDS_PER_BLOCK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_block,
  input  logic              odd_sense,
  input  logic              pair_valid,
  input  logic [WORD_W-1:0] rise_word,
  input  logic              rise_par,
  input  logic [WORD_W-1:0] fall_word,
  input  logic              fall_par,
  input  logic              frame_bit,
  input  logic              block_start,
  output logic              alarm_rise,
  output logic              alarm_fall,
  output logic              alarm_frame
);
  import parity_chk_pkg::*;

  chk_mode_e                    mode;
  logic [LANES-1:0][WORD_W-1:0] lane_word;
  logic [LANES-1:0]             lane_par;
  logic [LANES-1:0]             lane_alarm;
  logic                         word_en;
  logic                         block_en;

  assign mode     = chk_mode_e'(mode_block);
  assign word_en  = (mode == CHK_WORD);
  assign block_en = (mode == CHK_BLOCK);

  assign lane_word[LANE_RISE] = rise_word;
  assign lane_word[LANE_FALL] = fall_word;
  assign lane_par[LANE_RISE]  = rise_par;
  assign lane_par[LANE_FALL]  = fall_par;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    word_parity_lane #(.WORD_W(WORD_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .enable (word_en),
      .valid  (pair_valid),
      .word   (lane_word[g]),
      .par    (lane_par[g]),
      .odd    (odd_sense),
      .alarm  (lane_alarm[g])
    );
  end

  block_parity_acc #(
    .WORD_W          (WORD_W),
    .WORDS_PER_BLOCK (WORDS_PER_BLOCK)
  ) u_block (
    .clk       (clk),
    .rst       (rst),
    .enable    (block_en),
    .valid     (pair_valid),
    .start     (block_start),
    .rise_word (rise_word),
    .fall_word (fall_word),
    .frame     (frame_bit),
    .odd       (odd_sense),
    .alarm     (alarm_frame)
  );

  assign alarm_rise = lane_alarm[LANE_RISE];
  assign alarm_fall = lane_alarm[LANE_FALL];

  // R9: word alarms only follow a word-mode cycle
  p_word_mode_only_r9: assert property (@(posedge clk) disable iff (rst)
    (alarm_rise || alarm_fall) |-> $past(!mode_block));

  // R9: frame alarm only follows a block-mode cycle
  p_block_mode_only_r9: assert property (@(posedge clk) disable iff (rst)
    alarm_frame |-> $past(mode_block));

  // R10: no alarm of any kind without a valid pair
  p_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (alarm_rise || alarm_fall || alarm_frame) |-> $past(pair_valid));

  // R1: outputs are quiet right after a reset cycle
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !(alarm_rise || alarm_fall || alarm_frame));

endmodule

// File: tb/dual_edge_parity_checker_bench.sv
module dual_edge_parity_checker_bench;

  localparam int W = 16;

  typedef struct {
    logic  r;
    logic  f;
    logic  b;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_block = 1'b0, odd_sense = 1'b0, pair_valid = 1'b0;
  logic [W-1:0] rise_word = '0, fall_word = '0;
  logic rise_par = 1'b0, fall_par = 1'b0, frame_bit = 1'b0, block_start = 1'b0;
  logic alarm_rise, alarm_fall, alarm_frame;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];

  // bench model of block state
  bit m_open = 0;
  int m_cnt  = 0;
  bit m_acc  = 0;
  bit m_fbit = 0;

  always #10 clk = ~clk;

  dual_edge_parity_checker u_dual_edge_parity_checker (
    .clk(clk), .rst(rst), .mode_block(mode_block), .odd_sense(odd_sense),
    .pair_valid(pair_valid), .rise_word(rise_word), .rise_par(rise_par),
    .fall_word(fall_word), .fall_par(fall_par), .frame_bit(frame_bit),
    .block_start(block_start), .alarm_rise(alarm_rise),
    .alarm_fall(alarm_fall), .alarm_frame(alarm_frame));

  function automatic bit ones_odd(input logic [W-1:0] w);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(w[i]);
    return c[0];
  endfunction

  // parity bit that makes the word pass under the current sense
  function automatic bit good_par(input logic [W-1:0] w, input bit odd);
    return ones_odd(w) ^ odd;
  endfunction

  task automatic step(input bit mode, input bit odd, input bit v,
                      input logic [W-1:0] rw, input bit rp,
                      input logic [W-1:0] fw, input bit fp,
                      input bit fr, input bit st, input string tag);
    exp_t e;
    bit done;
    bit cyc_odd;
    @(negedge clk);
    mode_block = mode; odd_sense = odd; pair_valid = v;
    rise_word = rw; rise_par = rp; fall_word = fw; fall_par = fp;
    frame_bit = fr; block_start = st;
    e.tag = tag;
    e.r = !mode && v && ((ones_odd(rw) ^ rp) != odd);
    e.f = !mode && v && ((ones_odd(fw) ^ fp) != odd);
    e.b = 1'b0;
    cyc_odd = ones_odd(rw) ^ ones_odd(fw);
    if (!mode) begin
      m_open = 0;
    end else if (v && st) begin
      m_open = 1; m_cnt = 1; m_acc = cyc_odd; m_fbit = fr;
    end else if (v && m_open) begin
      m_acc ^= cyc_odd;
      m_cnt++;
      done = (m_cnt == 2);
      if (done) begin
        e.b = ((m_acc ^ m_fbit) != odd);
        m_open = 0;
      end
    end
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(mode_block, odd_sense, 1'b0, 16'hFFFF, 1'b0, 16'h0001, 1'b0, 1'b1, 1'b1, tag);
  endtask

  // monitor: compare one queued entry a quarter period after each edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (alarm_rise !== e.r || alarm_fall !== e.f || alarm_frame !== e.b) begin
        n_bad++;
        $display("FAIL %s: got rise/fall/frame=%b%b%b expected %b%b%b",
                 e.tag, alarm_rise, alarm_fall, alarm_frame, e.r, e.f, e.b);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [W-1:0] a, b2, c, d;

  initial begin
    a = 16'h1234; b2 = 16'h00F1; c = 16'hA5A5; d = 16'h8001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (alarm_rise !== 1'b0 || alarm_fall !== 1'b0 || alarm_frame !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got %b%b%b expected 000", alarm_rise, alarm_fall, alarm_frame);
    end
    rst = 1'b0;

    // R1 first cycle after reset
    idle("R1");
    // R2/R3/R4 word mode, even sense, all good
    step(0, 0, 1, a, good_par(a, 0), b2, good_par(b2, 0), 0, 0, "R4 even good");
    step(0, 0, 1, a, !good_par(a, 0), b2, good_par(b2, 0), 0, 0, "R2 rise bad");
    step(0, 0, 1, c, good_par(c, 0), d, !good_par(d, 0), 0, 0, "R3 fall bad only");
    step(0, 0, 1, c, !good_par(c, 0), d, !good_par(d, 0), 0, 0, "R3 both bad");
    idle("R2 pulse ends");
    // R4 odd sense
    step(0, 1, 1, a, good_par(a, 1), b2, good_par(b2, 1), 0, 0, "R4 odd good");
    step(0, 1, 1, a, good_par(a, 0), b2, good_par(b2, 0), 0, 0, "R4 odd with even bits");
    // R10 invalid with bad parity
    step(0, 0, 0, a, !good_par(a, 0), b2, !good_par(b2, 0), 0, 0, "R10 no valid");
    // R9 frame alarm held low in word mode
    step(0, 0, 1, a, good_par(a, 0), b2, good_par(b2, 0), 1, 1, "R9 word mode frame");
    step(0, 0, 1, c, good_par(c, 0), d, good_par(d, 0), 0, 0, "R9 word mode frame");

    // R5 good block, even sense; frame = parity of all data
    step(1, 0, 1, a, !good_par(a, 0), b2, 0, ones_odd(a)^ones_odd(b2)^ones_odd(c)^ones_odd(d), 1, "R9 block word alarms low");
    step(1, 0, 1, c, 0, d, 1, 0, 0, "R5 good block");
    // R5 bad block
    step(1, 0, 1, a, 0, b2, 0, !(ones_odd(a)^ones_odd(b2)^ones_odd(c)^ones_odd(d)), 1, "R5 first pair");
    step(1, 0, 1, c, 0, d, 0, 0, 0, "R5 bad block");
    // R5 with a gap, odd sense
    step(1, 1, 1, a, 0, a, 0, 1, 1, "R5 odd first");
    idle("R10 gap in block");
    step(1, 1, 1, c, 0, d, 0, 0, 0, "R5 odd sense block");
    // R6 frame changes on second pair are ignored
    step(1, 0, 1, a, 0, b2, 0, ones_odd(a)^ones_odd(b2)^ones_odd(c)^ones_odd(d), 1, "R6 first");
    step(1, 0, 1, c, 0, d, 0, 1, 0, "R6 frame ignored");
    step(1, 0, 1, a, 0, b2, 0, ones_odd(a)^ones_odd(b2)^ones_odd(c)^ones_odd(d), 1, "R6 first");
    step(1, 0, 1, c, 0, d, 0, 0, 0, "R6 frame ignored");
    // R7 restart mid block
    step(1, 0, 1, a, 0, a, 0, 1, 1, "R7 partial");
    step(1, 0, 1, c, 0, b2, 0, ones_odd(c)^ones_odd(b2)^ones_odd(a)^ones_odd(d), 1, "R7 restart");
    step(1, 0, 1, a, 0, d, 0, 0, 0, "R7 restarted block good");
    // R8 pairs outside a block
    step(1, 0, 1, a, 0, b2, 0, 1, 0, "R8 outside block");
    step(1, 0, 1, c, 0, d, 0, 1, 0, "R8 outside block");
    step(1, 0, 1, 16'h0001, 0, 16'h0000, 0, 0, 0, "R8 outside block");
    // mode change closes a block
    step(1, 0, 1, a, 0, b2, 0, 0, 1, "R9 open then leave");
    step(0, 0, 1, 16'h0001, 0, 16'h0000, 0, 0, 0, "R9 word after block");
    step(1, 0, 1, c, 0, d, 0, 0, 0, "R8 block closed by mode");
    idle("R10 end");
    idle("R10 end");

    repeat (3) @(posedge clk);
    #6;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule